// File: doc/BRIEF.md
# Flit-to-Packet Reassembler

This block sits on the receive side of one virtual network in a tile's network interface. Flits from the router are written into a small input buffer. The block decodes each flit's kind and channel fields and gathers the payloads into a packet-wide accumulation register. When a closing flit arrives, the completed packet is pushed into an output packet FIFO. The consuming unit in the tile, for example a cache controller, drains that FIFO with a valid/ready handshake.

Back-pressure uses credits. The router starts with as many credits as the input buffer has entries. It spends one credit for each flit it sends. The block returns one credit each time a flit leaves the input buffer. If a flit would complete a packet while the packet FIFO is full, that flit waits at the head of the input buffer. Its credit is held until space appears, so the router runs out of credits and stops sending.

Top module: `flit_packet_assembler`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, pkt_valid_o, credit_o and err_o are all 0.
- R2: A flit is {kind[1:0], vcid[VC_W-1:0], payload[PAY_W-1:0]}, with the kind code in the top two bits. The kind codes are HEAD=0, BODY=1, TAIL=2 and HT (head and tail in one flit)=3.
- R3: Payloads are placed in receive order, starting at the least significant PAY_W-bit slot. For example, HEAD 0x20, BODY 0x40, BODY 0x60, TAIL 0x10 produce the packet 0x10604020.
- R4: An HT flit completes a packet on its own. Its payload is in slot 0 and all other bits are 0. Any partly gathered packet is dropped.
- R5: A packet with fewer than MAX_FLITS flits has its unused high slots set to zero.
- R6: A HEAD flit that arrives while a packet is open drops the partial packet and starts a new one with its own payload in slot 0.
- R7: A BODY or TAIL flit that arrives with no open packet is discarded. It produces a one-cycle pulse on err_o and no packet.
- R8: A flit whose vcid differs from VNET_ID is discarded. It produces a one-cycle pulse on err_o and no packet.
- R9: credit_o pulses for exactly one cycle for every flit removed from the input buffer, including discarded flits.
- R10: When the packet FIFO is full, a flit that would complete a packet is not removed and returns no credit. It is processed once the consumer frees an entry.
- R11: Packets leave in completion order. pkt_o stays stable while pkt_valid_o is high and pkt_ready_i is low.
- R12: Flits beyond MAX_FLITS within one packet have their payload dropped. The packet keeps its first MAX_FLITS payloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid_i | input | 1 | A flit is presented this cycle (the router holds a credit for it) |
| flit_i | input | 2+VC_W+PAY_W | Flit: kind, channel id, payload |
| credit_o | output | 1 | One credit returned to the router |
| pkt_valid_o | output | 1 | Packet FIFO holds a packet |
| pkt_o | output | MAX_FLITS*PAY_W | Head packet, with the first flit in the low slot |
| pkt_ready_i | input | 1 | Consumer takes the head packet |
| err_o | output | 1 | Pulse for a flit that was discarded |

## Verification
The bench builds the block with its defaults: 8-bit payloads, a 2-bit channel id with VNET_ID 1, four slots per packet, a four-entry input buffer and a two-entry packet FIFO. With a packet FIFO only two deep, three single-flit packets are enough to reach the full-FIFO stall and the withheld credit. Four slots make the slot overflow reachable with a five-flit packet. The bench also checks zero-fill with a two-flit packet and the restart on a HEAD that arrives mid-packet.

// File: rtl/reasm_pkg.sv
package reasm_pkg;
    typedef enum logic [1:0] {
        FK_HEAD = 2'd0,
        FK_BODY = 2'd1,
        FK_TAIL = 2'd2,
        FK_HT   = 2'd3
    } flit_kind_e;
endpackage

// File: rtl/reasm_fifo.sv
module reasm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (s_q.cnt == '0);
    assign full    = (int'(s_q.cnt) == DEPTH);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[s_q.rd];

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wr = bump(s_q.wr);
        if (do_pop)  s_d.rd = bump(s_q.rd);
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= wdata;
    end
endmodule

// File: rtl/reasm_core.sv
module reasm_core
    import reasm_pkg::*;
#(
    parameter int PAY_W     = 8,
    parameter int VC_W      = 2,
    parameter int MAX_FLITS = 4,
    parameter int VNET_ID   = 1,
    localparam int FLIT_W   = 2 + VC_W + PAY_W,
    localparam int PKT_W    = MAX_FLITS * PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [FLIT_W-1:0] head_flit,
    input  logic              pf_full,
    output logic              pop,
    output logic              push_pkt,
    output logic [PKT_W-1:0]  pkt_data,
    output logic              credit_o,
    output logic              err_o
);
    localparam int IDX_W = $clog2(MAX_FLITS + 1);

    typedef struct packed {
        logic [PKT_W-1:0] acc;
        logic [IDX_W-1:0] idx;
        logic             open;
        logic             credit;
        logic             err;
    } st_t;

    st_t s_d, s_q;

    flit_kind_e       kind;
    logic [VC_W-1:0]  vcid;
    logic [PAY_W-1:0] pay;
    logic [PKT_W-1:0] merged;
    logic [PKT_W-1:0] single;
    logic             bad_vc;
    logic             completes;
    logic             room;

    assign kind     = flit_kind_e'(head_flit[FLIT_W-1 -: 2]);
    assign vcid     = head_flit[PAY_W +: VC_W];
    assign pay      = head_flit[PAY_W-1:0];
    assign room     = int'(s_q.idx) < MAX_FLITS;
    assign single   = PKT_W'(pay);
    assign credit_o = s_q.credit;
    assign err_o    = s_q.err;

    always_comb begin
        merged = s_q.acc;
        if (room) merged[s_q.idx*PAY_W +: PAY_W] = pay;
    end

    always_comb begin
        s_d       = s_q;
        s_d.credit = 1'b0;
        s_d.err    = 1'b0;
        pop       = 1'b0;
        push_pkt  = 1'b0;
        pkt_data  = (kind == FK_HT) ? single : merged;
        bad_vc    = vcid != VC_W'(VNET_ID);
        completes = !bad_vc && (kind == FK_HT || (kind == FK_TAIL && s_q.open));
        if (head_valid && !(completes && pf_full)) begin
            pop        = 1'b1;
            s_d.credit = 1'b1;
            if (bad_vc) begin
                s_d.err = 1'b1;
            end else begin
                case (kind)
                    FK_HEAD: begin
                        s_d.acc  = single;
                        s_d.idx  = IDX_W'(1);
                        s_d.open = 1'b1;
                    end
                    FK_BODY: begin
                        if (s_q.open) begin
                            s_d.acc = merged;
                            if (room) s_d.idx = s_q.idx + IDX_W'(1);
                        end else begin
                            s_d.err = 1'b1;
                        end
                    end
                    FK_TAIL: begin
                        if (s_q.open) begin
                            push_pkt = 1'b1;
                            s_d.acc  = '0;
                            s_d.idx  = '0;
                            s_d.open = 1'b0;
                        end else begin
                            s_d.err = 1'b1;
                        end
                    end
                    default: begin
                        push_pkt = 1'b1;
                        s_d.acc  = '0;
                        s_d.idx  = '0;
                        s_d.open = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/flit_packet_assembler.sv
module flit_packet_assembler #(
    parameter int PAY_W     = 8,
    parameter int VC_W      = 2,
    parameter int MAX_FLITS = 4,
    parameter int IN_DEPTH  = 4,
    parameter int PKT_DEPTH = 2,
    parameter int VNET_ID   = 1,
    localparam int FLIT_W   = 2 + VC_W + PAY_W,
    localparam int PKT_W    = MAX_FLITS * PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flit_valid_i,
    input  logic [FLIT_W-1:0] flit_i,
    output logic              credit_o,
    output logic              pkt_valid_o,
    output logic [PKT_W-1:0]  pkt_o,
    input  logic              pkt_ready_i,
    output logic              err_o
);
    logic              in_empty, in_full, in_pop;
    logic [FLIT_W-1:0] in_head;
    logic              pf_empty, pf_full, pf_push;
    logic [PKT_W-1:0]  pf_wdata;

    reasm_fifo #(.WIDTH(FLIT_W), .DEPTH(IN_DEPTH)) u_in_buf (
        .clk(clk), .rst_n(rst_n),
        .push(flit_valid_i), .wdata(flit_i),
        .pop(in_pop), .rdata(in_head),
        .empty(in_empty), .full(in_full)
    );

    reasm_core #(
        .PAY_W(PAY_W), .VC_W(VC_W), .MAX_FLITS(MAX_FLITS), .VNET_ID(VNET_ID)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!in_empty), .head_flit(in_head), .pf_full(pf_full),
        .pop(in_pop), .push_pkt(pf_push), .pkt_data(pf_wdata),
        .credit_o(credit_o), .err_o(err_o)
    );

    reasm_fifo #(.WIDTH(PKT_W), .DEPTH(PKT_DEPTH)) u_pkt_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(pf_push), .wdata(pf_wdata),
        .pop(pkt_ready_i), .rdata(pkt_o),
        .empty(pf_empty), .full(pf_full)
    );

    assign pkt_valid_o = !pf_empty;

    logic unused_full;
    assign unused_full = in_full;
endmodule

// File: rtl/reasm_checker.sv
module reasm_checker #(
    parameter int IN_DEPTH = 4,
    parameter int PKT_W    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flit_valid_i,
    input logic             credit_o,
    input logic             err_o,
    input logic             pkt_valid_o,
    input logic             pkt_ready_i,
    input logic [PKT_W-1:0] pkt_o
);
    localparam int OW = $clog2(IN_DEPTH + 2) + 1;
    logic [OW-1:0] outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else        outstanding <= outstanding + OW'(flit_valid_i) - OW'(credit_o);
    end

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pkt_valid_o && !credit_o && !err_o));

    // R9
    a_r9_credit_has_flit: assert property (@(posedge clk) disable iff (!rst_n)
        credit_o |-> (outstanding != '0));

    // R9 / R10
    a_r9_in_flight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= IN_DEPTH);

    // R7 / R8
    a_r7_err_with_credit: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> credit_o);

    // R11
    a_r11_hold_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_o)));
endmodule

bind flit_packet_assembler reasm_checker #(.IN_DEPTH(IN_DEPTH), .PKT_W(PKT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flit_valid_i(flit_valid_i), .credit_o(credit_o),
    .err_o(err_o), .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i), .pkt_o(pkt_o)
);

// File: tb/tb_flit_packet_assembler.sv
module tb_flit_packet_assembler;
    localparam int PAY_W = 8, VC_W = 2, MAX_FLITS = 4, IN_DEPTH = 4, PKT_DEPTH = 2, VNET_ID = 1;
    localparam int FLIT_W = 2 + VC_W + PAY_W;
    localparam int PKT_W  = MAX_FLITS * PAY_W;
    localparam logic [1:0] K_HEAD = 2'd0, K_BODY = 2'd1, K_TAIL = 2'd2, K_HT = 2'd3;
    localparam logic [VC_W-1:0] VC = VC_W'(VNET_ID);

    logic clk = 0, rst_n = 0, flit_valid = 0, pkt_ready = 0;
    logic [FLIT_W-1:0] flit = '0;
    logic credit, pkt_valid, err;
    logic [PKT_W-1:0] pkt;
    int checks = 0, errors = 0, sent = 0, returned = 0, err_seen = 0;

    always #2 clk = ~clk;

    flit_packet_assembler #(
        .PAY_W(PAY_W), .VC_W(VC_W), .MAX_FLITS(MAX_FLITS),
        .IN_DEPTH(IN_DEPTH), .PKT_DEPTH(PKT_DEPTH), .VNET_ID(VNET_ID)
    ) dut (
        .clk(clk), .rst_n(rst_n), .flit_valid_i(flit_valid), .flit_i(flit),
        .credit_o(credit), .pkt_valid_o(pkt_valid), .pkt_o(pkt),
        .pkt_ready_i(pkt_ready), .err_o(err)
    );

    always @(negedge clk) begin
        if (credit) returned++;
        if (err) err_seen++;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [VC_W-1:0] vc, input logic [PAY_W-1:0] p);
        @(negedge clk);
        while (sent - returned >= IN_DEPTH) @(negedge clk);
        flit_valid = 1'b1;
        flit = {k, vc, p};
        sent++;
        @(negedge clk);
        flit_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pkt(input string req, input logic [PKT_W-1:0] exp);
        int waited = 0;
        @(negedge clk);
        while (!pkt_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        check({req, " packet present"}, 64'(pkt_valid), 64'd1);
        check(req, 64'(pkt), 64'(exp));
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    task automatic t_reset();
        idle(3);
        check("R1 pkt_valid", 64'(pkt_valid), 64'd0);
        check("R1 credit", 64'(credit), 64'd0);
        check("R1 err", 64'(err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pkt_valid after release", 64'(pkt_valid), 64'd0);
        check("R1 err after release", 64'(err), 64'd0);
    endtask

    task automatic t_order();
        send(K_HEAD, VC, 8'h20); send(K_BODY, VC, 8'h40);
        send(K_BODY, VC, 8'h60); send(K_TAIL, VC, 8'h10);
        expect_pkt("R2 R3 order", 32'h10604020);
    endtask

    task automatic t_ht();
        send(K_HEAD, VC, 8'h77);
        send(K_HT, VC, 8'h5A);
        expect_pkt("R4 single flit", 32'h0000005A);
    endtask

    task automatic t_short();
        send(K_HEAD, VC, 8'hAA); send(K_TAIL, VC, 8'hBB);
        expect_pkt("R5 zero fill", 32'h0000BBAA);
    endtask

    task automatic t_restart();
        send(K_HEAD, VC, 8'h11); send(K_BODY, VC, 8'h22);
        send(K_HEAD, VC, 8'h33); send(K_TAIL, VC, 8'h44);
        expect_pkt("R6 restart", 32'h00004433);
    endtask

    task automatic t_orphan();
        int e0 = err_seen;
        send(K_BODY, VC, 8'h01);
        idle(6);
        check("R7 orphan body err", 64'(err_seen - e0), 64'd1);
        send(K_TAIL, VC, 8'h02);
        idle(6);
        check("R7 orphan tail err", 64'(err_seen - e0), 64'd2);
        check("R7 no packet", 64'(pkt_valid), 64'd0);
    endtask

    task automatic t_badvc();
        int e0 = err_seen;
        send(K_HT, VC_W'(VNET_ID + 1), 8'h99);
        idle(6);
        check("R8 wrong channel err", 64'(err_seen - e0), 64'd1);
        check("R8 no packet", 64'(pkt_valid), 64'd0);
        check("R9 credits balance", 64'(returned), 64'(sent));
    endtask

    task automatic t_full();
        send(K_HT, VC, 8'hA1); send(K_HT, VC, 8'hA2); send(K_HT, VC, 8'hA3);
        idle(10);
        check("R10 credit withheld", 64'(sent - returned), 64'd1);
        check("R11 head held", 64'(pkt), 64'h000000A1);
        expect_pkt("R11 first", 32'h000000A1);
        expect_pkt("R11 second", 32'h000000A2);
        expect_pkt("R10 stalled third", 32'h000000A3);
        idle(6);
        check("R10 credit after drain", 64'(returned), 64'(sent));
    endtask

    task automatic t_overflow();
        send(K_HEAD, VC, 8'h01); send(K_BODY, VC, 8'h02); send(K_BODY, VC, 8'h03);
        send(K_BODY, VC, 8'h04); send(K_TAIL, VC, 8'h05);
        expect_pkt("R12 extra dropped", 32'h04030201);
        idle(6);
        check("R9 credits after overflow", 64'(returned), 64'(sent));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_ht();
        t_short();
        t_restart();
        t_orphan();
        t_badvc();
        t_full();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule